// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits beside one processor and decides which single interrupt, if any, is offered to it. It holds four pieces of state: the processor's current priority threshold, a priority register for inter-processor messages, the number of the pending source and that source's priority. Numerically lower priority values are more favored. Interrupt sources offer a (source, priority) pair and receive an accept or refuse answer. A source that loses the single pending slot to a more favored arrival is handed back on a redelivery port so that the source side can offer it again.

The processor issues four commands: accept the pending interrupt, set the priority threshold, set the message priority, and end-of-interrupt. A refused delivery leaves a sticky "resend needed" flag. When the processor later relaxes its threshold, or makes the message priority less favored, the flag is consumed and a one-cycle resend request asks the sources to rescan. A fixed arbiter gives processor commands precedence over deliveries, so each state change is atomic.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the message priority 0xFF, the pending priority 0xFF, the pending source 0 (0 means nothing pending), `irq_out` is low and no response pulse is high; an accept issued then returns 0x00000000.
- R2: `irq_out` is high exactly when the pending source is non-zero and the pending priority is numerically below the threshold.
- R3: A delivery at priority p is accepted (`dlv_ok`=1) only when the threshold, the message priority and the pending priority are all numerically greater than p; the new source and p then replace the pending slot.
- R4: A source displaced from the pending slot is returned on `redeliver_valid`/`redeliver_src` in the response cycle, unless it is 0 or the message source code 2, which is dropped.
- R5: A refused delivery leaves the pending slot unchanged and sets the resend-needed flag.
- R6: Accept (op code 0) returns the threshold in bits 31:24 and the pending source in bits 23:0 of `cmd_result`; if a source was pending, the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source 0.
- R7: Set message priority (op code 2, value in `cmd_data[7:0]`) to m: if m is below the threshold and not above the pending priority, the pending source is displaced and source code 2 becomes pending at priority m.
- R8: When set message priority makes m numerically greater than the previous value, a set resend-needed flag is cleared and `resend_req` pulses; otherwise the flag is untouched.
- R9: Set threshold (op code 1, value in `cmd_data[31:24]`) to a numerically larger value loads it; if the message priority is below the new threshold and not above the pending priority, source code 2 becomes pending at the message priority; a set resend-needed flag is cleared with a `resend_req` pulse.
- R10: Set threshold to a numerically smaller value loads it; if the new value is not above the pending priority the pending source is displaced, the slot cleared and the pending priority set to 0xFF.
- R11: Set threshold to the value already held changes nothing and produces no displacement or resend pulse.
- R12: End-of-interrupt (op code 3) applies the R9 path with the threshold from `cmd_data[31:24]` whatever its value, and pulses `eoi_valid` with `cmd_data[23:0]` on `eoi_src` unless that source is code 2.
- R13: A command and a delivery offered together: the command is taken, `dlv_ready` is low, and the delivery is taken on the next cycle it is still offered; every response appears on the registered outputs one clock edge after the op is taken, and `cmd_done` and `dlv_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 2 | 0 accept, 1 set threshold, 2 set message priority, 3 end-of-interrupt |
| cmd_data | input | 32 | Priority in bits 31:24 (or 7:0 for op 2), source in bits 23:0 |
| cmd_done | output | 1 | One-cycle command completion pulse |
| cmd_result | output | 32 | Accept result word, loaded by op 0 |
| dlv_valid | input | 1 | Source delivery offered |
| dlv_src | input | 24 | Offered source number |
| dlv_pri | input | 8 | Offered priority |
| dlv_ready | output | 1 | Delivery can be taken this cycle |
| dlv_done | output | 1 | One-cycle delivery completion pulse |
| dlv_ok | output | 1 | Delivery accepted (valid with dlv_done) |
| irq_out | output | 1 | Interrupt line to the processor |
| redeliver_valid | output | 1 | Displaced source must be offered again |
| redeliver_src | output | 24 | Displaced source number |
| resend_req | output | 1 | Sources must rescan refused interrupts |
| eoi_valid | output | 1 | End-of-interrupt forwarded to sources |
| eoi_src | output | 24 | Source receiving the end-of-interrupt |

## Verification
Every op taken at a rising edge produces its done pulse, result word, displacement, resend and end-of-interrupt outputs right after that edge, and `irq_out` follows the updated state at the same moment. The driver pushes one expected item per op, computed by a priority model written from the requirements, and the monitor compares all response fields and `irq_out` at the falling edge that follows the taking edge. For the simultaneous command/delivery case the bench checks that the delivery is stalled for exactly one edge and that its response arrives one cycle after the command's.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W    = 24,
  parameter int PRI_W    = 8,
  parameter int IPI_CODE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [PRI_W+SRC_W-1:0] cmd_data,
  output logic                   cmd_done,
  output logic [PRI_W+SRC_W-1:0] cmd_result,
  input  logic                   dlv_valid,
  input  logic [SRC_W-1:0]       dlv_src,
  input  logic [PRI_W-1:0]       dlv_pri,
  output logic                   dlv_ready,
  output logic                   dlv_done,
  output logic                   dlv_ok,
  output logic                   irq_out,
  output logic                   redeliver_valid,
  output logic [SRC_W-1:0]       redeliver_src,
  output logic                   resend_req,
  output logic                   eoi_valid,
  output logic [SRC_W-1:0]       eoi_src
);
  localparam int WORD_W = PRI_W + SRC_W;
  localparam logic [SRC_W-1:0] IPI = SRC_W'(IPI_CODE);
  localparam logic [1:0] OP_ACCEPT = 2'd0, OP_THRESH = 2'd1, OP_MSG = 2'd2, OP_EOI = 2'd3;

  logic [PRI_W-1:0] cppr_q, mfrr_q, ppri_q;
  logic [SRC_W-1:0] xisr_q;
  logic             nr_q;

  logic [PRI_W-1:0] cppr_n, mfrr_n, ppri_n;
  logic [SRC_W-1:0] xisr_n, rej;
  logic             nr_n, rs, ok, ev;

  wire [PRI_W-1:0] new_pri = cmd_data[WORD_W-1 -: PRI_W];
  wire [PRI_W-1:0] msg_pri = cmd_data[PRI_W-1:0];
  wire [SRC_W-1:0] cmd_src = cmd_data[SRC_W-1:0];
  wire             dlv_go  = dlv_valid && !cmd_valid;
  wire             lower   = cmd_valid && ((cmd_op == OP_THRESH && new_pri > cppr_q) || cmd_op == OP_EOI);
  wire             raise   = cmd_valid && cmd_op == OP_THRESH && new_pri < cppr_q;

  assign dlv_ready = !cmd_valid;
  assign irq_out   = (xisr_q != '0) && (ppri_q < cppr_q);

  always_comb begin
    cppr_n = cppr_q;
    mfrr_n = mfrr_q;
    ppri_n = ppri_q;
    xisr_n = xisr_q;
    nr_n   = nr_q;
    rej    = '0;
    rs     = 1'b0;
    ok     = 1'b0;
    ev     = 1'b0;
    if (cmd_valid && cmd_op == OP_ACCEPT) begin
      if (xisr_q != '0) begin
        cppr_n = ppri_q;
        ppri_n = '1;
        xisr_n = '0;
      end
    end else if (lower) begin
      cppr_n = new_pri;
      if (mfrr_q < new_pri && mfrr_q <= ppri_q) begin
        rej    = xisr_q;
        xisr_n = IPI;
        ppri_n = mfrr_q;
      end
      rs   = nr_q;
      nr_n = 1'b0;
      ev   = (cmd_op == OP_EOI) && (cmd_src != IPI);
    end else if (raise) begin
      cppr_n = new_pri;
      if (new_pri <= ppri_q) begin
        rej    = xisr_q;
        xisr_n = '0;
        ppri_n = '1;
      end
    end else if (cmd_valid && cmd_op == OP_MSG) begin
      mfrr_n = msg_pri;
      if (msg_pri < cppr_q && msg_pri <= ppri_q) begin
        rej    = xisr_q;
        xisr_n = IPI;
        ppri_n = msg_pri;
      end
      if (msg_pri > mfrr_q) begin
        rs   = nr_q;
        nr_n = 1'b0;
      end
    end else if (dlv_go) begin
      if (cppr_q > dlv_pri && mfrr_q > dlv_pri && ppri_q > dlv_pri) begin
        ok     = 1'b1;
        rej    = xisr_q;
        xisr_n = dlv_src;
        ppri_n = dlv_pri;
      end else begin
        nr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q          <= '0;
      mfrr_q          <= '1;
      ppri_q          <= '1;
      xisr_q          <= '0;
      nr_q            <= 1'b0;
      cmd_done        <= 1'b0;
      cmd_result      <= '0;
      dlv_done        <= 1'b0;
      dlv_ok          <= 1'b0;
      redeliver_valid <= 1'b0;
      redeliver_src   <= '0;
      resend_req      <= 1'b0;
      eoi_valid       <= 1'b0;
      eoi_src         <= '0;
    end else begin
      cppr_q          <= cppr_n;
      mfrr_q          <= mfrr_n;
      ppri_q          <= ppri_n;
      xisr_q          <= xisr_n;
      nr_q            <= nr_n;
      cmd_done        <= cmd_valid;
      dlv_done        <= dlv_go;
      dlv_ok          <= ok;
      redeliver_valid <= (rej != '0) && (rej != IPI);
      redeliver_src   <= rej;
      resend_req      <= rs;
      eoi_valid       <= ev;
      eoi_src         <= cmd_src;
      if (cmd_valid && cmd_op == OP_ACCEPT)
        cmd_result <= {cppr_q, xisr_q};
    end
  end
endmodule

module irq_presenter_chk #(
  parameter int SRC_W    = 24,
  parameter int PRI_W    = 8,
  parameter int IPI_CODE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [PRI_W-1:0] cmd_pri,
  input logic             dlv_valid,
  input logic             cmd_done,
  input logic             dlv_done,
  input logic             dlv_ok,
  input logic             irq_out,
  input logic             redeliver_valid,
  input logic [SRC_W-1:0] redeliver_src,
  input logic             resend_req,
  input logic             eoi_valid,
  input logic [SRC_W-1:0] eoi_src,
  input logic [PRI_W-1:0] cppr_q,
  input logic [SRC_W-1:0] xisr_q
);
  localparam logic [SRC_W-1:0] IPI = SRC_W'(IPI_CODE);

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n) $countones({cmd_done, dlv_done}) <= 1); // R13
  AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && dlv_valid) |=> !dlv_done); // R13
  AST_REDELIVER_SRC: assert property (@(posedge clk) disable iff (!rst_n) redeliver_valid |-> (redeliver_src != IPI && redeliver_src != '0)); // R4
  AST_EOI_NOT_IPI: assert property (@(posedge clk) disable iff (!rst_n) eoi_valid |-> eoi_src != IPI); // R12
  AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 2'd0) |=> !irq_out); // R6
  AST_REFUSE_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (dlv_valid && !cmd_valid) |=> (dlv_ok || xisr_q == $past(xisr_q))); // R5
  AST_SAME_THRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 2'd1 && cmd_pri == cppr_q) |=> (!redeliver_valid && !resend_req)); // R11
endmodule

bind irq_presenter irq_presenter_chk #(.SRC_W(SRC_W), .PRI_W(PRI_W), .IPI_CODE(IPI_CODE)) chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_pri(cmd_data[PRI_W+SRC_W-1 -: PRI_W]), .dlv_valid(dlv_valid),
  .cmd_done(cmd_done), .dlv_done(dlv_done), .dlv_ok(dlv_ok), .irq_out(irq_out),
  .redeliver_valid(redeliver_valid), .redeliver_src(redeliver_src),
  .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
  .cppr_q(cppr_q), .xisr_q(xisr_q)
);

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        dlv_valid = 1'b0;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_pri = '0;
  logic        cmd_done, dlv_ready, dlv_done, dlv_ok, irq_out;
  logic        redeliver_valid, resend_req, eoi_valid;
  logic [31:0] cmd_result;
  logic [23:0] redeliver_src, eoi_src;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_result(cmd_result), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
    .dlv_pri(dlv_pri), .dlv_ready(dlv_ready), .dlv_done(dlv_done), .dlv_ok(dlv_ok),
    .irq_out(irq_out), .redeliver_valid(redeliver_valid), .redeliver_src(redeliver_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  typedef struct packed {
    logic        is_cmd;
    logic [31:0] word;
    logic        ok;
    logic        rej_v;
    logic [23:0] rej_src;
    logic        rs;
    logic        ev;
    logic [23:0] ev_src;
    logic        irq;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_cppr = 8'h00, m_mfrr = 8'hFF, m_ppri = 8'hFF;
  logic [23:0] m_xisr = '0;
  logic        m_nr = 1'b0;

  task automatic check(input bit good, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t drop(input logic [23:0] r, input exp_t e);
    exp_t x = e;
    x.rej_v   = (r != 0) && (r != 24'd2);
    x.rej_src = x.rej_v ? r : 24'd0;
    return x;
  endfunction

  task automatic model_cmd(input logic [1:0] op, input logic [31:0] d, output exp_t e);
    logic [7:0]  np = d[31:24];
    logic [7:0]  mp = d[7:0];
    logic [23:0] r = '0;
    e = '0;
    e.is_cmd = 1'b1;
    if (op == 2'd0) begin
      e.word = {m_cppr, m_xisr};
      if (m_xisr != 0) begin m_cppr = m_ppri; m_ppri = 8'hFF; m_xisr = 0; end
    end else if (op == 2'd3 || (op == 2'd1 && np > m_cppr)) begin
      m_cppr = np;
      if (m_mfrr < np && m_mfrr <= m_ppri) begin r = m_xisr; m_xisr = 24'd2; m_ppri = m_mfrr; end
      e.rs = m_nr; m_nr = 1'b0;
      if (op == 2'd3 && d[23:0] != 24'd2) begin e.ev = 1'b1; e.ev_src = d[23:0]; end
    end else if (op == 2'd1 && np < m_cppr) begin
      m_cppr = np;
      if (np <= m_ppri) begin r = m_xisr; m_xisr = 0; m_ppri = 8'hFF; end
    end else if (op == 2'd2) begin
      if (mp < m_cppr && mp <= m_ppri) begin r = m_xisr; m_xisr = 24'd2; m_ppri = mp; end
      if (mp > m_mfrr) begin e.rs = m_nr; m_nr = 1'b0; end
      m_mfrr = mp;
    end
    e = drop(r, e);
    e.irq = (m_xisr != 0) && (m_ppri < m_cppr);
  endtask

  task automatic model_dlv(input logic [23:0] s, input logic [7:0] p, output exp_t e);
    logic [23:0] r = '0;
    e = '0;
    if (m_cppr > p && m_mfrr > p && m_ppri > p) begin
      e.ok = 1'b1; r = m_xisr; m_xisr = s; m_ppri = p;
    end else m_nr = 1'b1;
    e = drop(r, e);
    e.irq = (m_xisr != 0) && (m_ppri < m_cppr);
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] d, input string tag);
    exp_t e;
    model_cmd(op, d, e);
    eq.push_back(e); tq.push_back(tag);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic do_dlv(input logic [23:0] s, input logic [7:0] p, input string tag);
    exp_t e;
    model_dlv(s, p, e);
    eq.push_back(e); tq.push_back(tag);
    @(negedge clk); dlv_valid = 1'b1; dlv_src = s; dlv_pri = p;
    @(negedge clk); dlv_valid = 1'b0;
  endtask

  task automatic do_both(input logic [1:0] op, input logic [31:0] d, input logic [23:0] s, input logic [7:0] p);
    exp_t e1, e2;
    model_cmd(op, d, e1); eq.push_back(e1); tq.push_back("R13 command first");
    model_dlv(s, p, e2);  eq.push_back(e2); tq.push_back("R13 stalled delivery");
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    dlv_valid = 1'b1; dlv_src = s; dlv_pri = p;
    #1 check(dlv_ready == 1'b0, "R13 dlv_ready low under command", dlv_ready, 0);
    @(negedge clk); cmd_valid = 1'b0;
    check(dlv_done == 1'b0, "R13 delivery stalled one edge", dlv_done, 0);
    @(negedge clk); dlv_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_done || dlv_done)) begin
      if (eq.size() == 0) begin
        check(1'b0, "R13 unexpected response", {cmd_done, dlv_done}, 0);
      end else begin
        exp_t e, a;
        string t;
        e = eq.pop_front(); t = tq.pop_front();
        a = '0;
        a.is_cmd  = cmd_done;
        a.word    = (e.is_cmd && cmd_op_was_accept(e)) ? cmd_result : 32'd0;
        a.ok      = dlv_done ? dlv_ok : 1'b0;
        a.rej_v   = redeliver_valid;
        a.rej_src = redeliver_valid ? redeliver_src : 24'd0;
        a.rs      = resend_req;
        a.ev      = eoi_valid;
        a.ev_src  = eoi_valid ? eoi_src : 24'd0;
        a.irq     = irq_out;
        check(a == e, t, a, e);
      end
    end
  end

  function automatic bit cmd_op_was_accept(input exp_t e);
    return e.word != 32'd0;
  endfunction

  initial begin
    #4_000_000;
    check(1'b0, "R13 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq_out && !cmd_done && !dlv_done && !redeliver_valid && !resend_req && !eoi_valid,
          "R1 reset outputs", {irq_out, cmd_done, dlv_done, redeliver_valid, resend_req, eoi_valid}, 0);
    do_cmd(2'd0, 32'h0, "R1 R6 accept after reset");
    check(cmd_result == 32'h0, "R1 reset accept word", cmd_result, 0);
    do_dlv(24'h100, 8'h05, "R5 refused at threshold 0");
    do_cmd(2'd1, 32'hFF00_0000, "R9 lower threshold takes resend");
    do_dlv(24'h100, 8'h05, "R3 R2 first delivery");
    do_dlv(24'h200, 8'h03, "R4 displace 0x100");
    do_dlv(24'h300, 8'h03, "R5 refused equal priority");
    do_cmd(2'd0, 32'h0, "R6 accept 0x200");
    check(cmd_result == 32'hFF00_0200, "R6 accept word", cmd_result, 32'hFF00_0200);
    do_cmd(2'd3, 32'hFF00_0200, "R12 R9 eoi with resend");
    do_cmd(2'd2, 32'h0000_0010, "R7 message becomes pending");
    do_dlv(24'h400, 8'h08, "R4 message code dropped");
    do_cmd(2'd1, 32'h0800_0000, "R10 raise displaces 0x400");
    do_dlv(24'h500, 8'h09, "R5 refused above threshold");
    do_cmd(2'd1, 32'h0800_0000, "R11 equal threshold no-op");
    do_cmd(2'd2, 32'h0000_0020, "R8 message less favored resends");
    do_cmd(2'd2, 32'h0000_0030, "R8 flag already cleared");
    do_cmd(2'd1, 32'h4000_0000, "R9 lower picks up message");
    do_cmd(2'd0, 32'h0, "R6 accept message");
    check(cmd_result == 32'h4000_0002, "R6 accept message word", cmd_result, 32'h4000_0002);
    do_cmd(2'd3, 32'hFF00_0002, "R12 eoi of message not forwarded");
    do_cmd(2'd2, 32'h0000_00FF, "R8 R7 message off");
    do_cmd(2'd0, 32'h0, "R6 accept message again");
    do_cmd(2'd1, 32'hFF00_0000, "R9 lower to 0xFF");
    do_both(2'd0, 32'h0, 24'h600, 8'h01);
    do_cmd(2'd0, 32'h0, "R6 accept 0x600");
    do_cmd(2'd3, 32'hFF00_0600, "R12 eoi forwarded");
    do_dlv(24'h700, 8'h20, "R3 deliver 0x700");
    do_cmd(2'd1, 32'h8000_0000, "R10 raise without displacement");
    do_cmd(2'd1, 32'h2000_0000, "R10 raise to pending priority");
    repeat (3) @(negedge clk);
    check(eq.size() == 0, "R13 all responses seen", eq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule